// File: doc/BRIEF.md
# Radio Power-State Sequencer

This block is the top-level state machine of a packet radio. It carries the transceiver from power-off through a one-cycle register initialisation into idle. From idle it can go to a low-current sleep state, or it can run one transmit or one receive session. While it does so it switches on the synthesizer, the power amplifier and the two data paths, each at the right moment.

A session first powers the synthesizer. It then waits a programmable number of microseconds for the synthesizer to settle. A transmit session adds a second programmable wait for the amplifier to ramp. Only then does the data path run. Each delay is a byte-wide field counted in ticks of an external 1 µs strobe. A session ends when the framer reports that the packet is complete, or when software withdraws the start bit. The session then passes through a done state that lasts until the next microsecond tick.

Top module: `radio_power_seq`

## Requirements
- R1: While `rst_n` is low, `state` is 0 (off) and every enable and `pkt_flag` are low. The first clock after release gives state 1 (init), and the next clock gives state 2 (idle).
- R2: In idle, with neither start bit set, `sleep_req` high together with `spi_cs_n` high moves to state 3 (sleep) on the next clock. Sleep returns to idle on the first clock at which `sleep_req` is low.
- R3: In idle, `sleep_req` has no effect while `spi_cs_n` is low: the state stays 2.
- R4: `tx_go` in idle steps through these states: 4 (tx start, one clock), 5 (synthesizer wait), 6 (amplifier wait) and 7 (tx data).
- R5: `rx_go` in idle (with `tx_go` low) steps through these states: 9 (rx start, one clock), 10 (synthesizer wait) and 11 (rx data).
- R6: A wait state whose field holds N leaves on the clock that follows the Nth `us_tick` counted inside it. N = 0 keeps the wait for a single clock. `tx_synth_dly` times state 5, `pa_dly` times state 6 and `rx_synth_dly` times state 10.
- R7: State 7 moves to 8 (tx done) on `pkt_done` or on `tx_go` low. State 11 moves to 12 (rx done) on `pkt_done` or on `rx_go` low.
- R8: States 8 and 12 hold until a clock with `us_tick` high, then return to idle.
- R9: `pkt_flag` is high exactly in states 7 and 11. It rises on the clock that enters a data state and falls on the clock that enters the done state.
- R10: With both `tx_go` and `rx_go` set in idle, the transmit sequence is taken (state 4).
- R11: `pll_en` is high in states 4, 5, 6, 7, 9, 10 and 11. `pa_en` is high in states 6 and 7. `tx_en` is high only in state 7 and `rx_en` only in state 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low chip reset; low means off |
| spi_cs_n | input | 1 | Host serial bus select, active low; high means the bus is idle |
| sleep_req | input | 1 | Sleep request bit |
| tx_go | input | 1 | Transmit start bit |
| rx_go | input | 1 | Receive start bit |
| tx_synth_dly | input | DLY_W | Transmit synthesizer settling, µs |
| pa_dly | input | DLY_W | Amplifier ramp time, µs |
| rx_synth_dly | input | DLY_W | Receive synthesizer settling, µs |
| pkt_done | input | 1 | Packet complete strobe from the framer |
| us_tick | input | 1 | One-clock strobe every microsecond |
| state | output | 4 | Current state code |
| pll_en | output | 1 | Synthesizer enable |
| pa_en | output | 1 | Power amplifier enable |
| tx_en | output | 1 | Transmit data path enable |
| rx_en | output | 1 | Receive data path enable |
| pkt_flag | output | 1 | Packet in progress |

## Verification
The bench uses the default delay width of 8 bits, so each delay field covers its full range up to 255. The bench sweeps every pairing of synthesizer and amplifier delays from a set that includes 0, small values and 255, on both the transmit and the receive path. It alternates between packet-complete endings and start-bit-withdrawn endings. Because ticks are issued one at a time, the exact tick that releases each wait can be observed at the ports, along with the zero-length skip and the largest count.

// File: rtl/radio_power_seq.sv
module radio_power_seq #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             sleep_req,
  input  logic             tx_go,
  input  logic             rx_go,
  input  logic [DLY_W-1:0] tx_synth_dly,
  input  logic [DLY_W-1:0] pa_dly,
  input  logic [DLY_W-1:0] rx_synth_dly,
  input  logic             pkt_done,
  input  logic             us_tick,
  output logic [3:0]       state,
  output logic             pll_en,
  output logic             pa_en,
  output logic             tx_en,
  output logic             rx_en,
  output logic             pkt_flag
);
  localparam logic [3:0] S_OFF = 4'd0, S_INIT = 4'd1, S_IDLE = 4'd2, S_SLEEP = 4'd3,
                         S_TXS = 4'd4, S_TXW = 4'd5, S_TXPA = 4'd6, S_TXD = 4'd7,
                         S_TXE = 4'd8, S_RXS = 4'd9, S_RXW = 4'd10, S_RXD = 4'd11,
                         S_RXE = 4'd12;

  logic [3:0]       nxt;
  logic [DLY_W-1:0] cnt, ld_val;
  logic             load, expired;

  assign expired = (cnt == '0);

  always_comb begin
    nxt    = state;
    load   = 1'b0;
    ld_val = '0;
    case (state)
      S_OFF:   nxt = S_INIT;
      S_INIT:  nxt = S_IDLE;
      S_IDLE:
        if (tx_go)                      nxt = S_TXS;
        else if (rx_go)                 nxt = S_RXS;
        else if (sleep_req && spi_cs_n) nxt = S_SLEEP;
      S_SLEEP: if (!sleep_req) nxt = S_IDLE;
      S_TXS: begin nxt = S_TXW; load = 1'b1; ld_val = tx_synth_dly; end
      S_TXW:
        if (expired) begin nxt = S_TXPA; load = 1'b1; ld_val = pa_dly; end
      S_TXPA:  if (expired) nxt = S_TXD;
      S_TXD:   if (pkt_done || !tx_go) nxt = S_TXE;
      S_TXE:   if (us_tick) nxt = S_IDLE;
      S_RXS: begin nxt = S_RXW; load = 1'b1; ld_val = rx_synth_dly; end
      S_RXW:   if (expired) nxt = S_RXD;
      S_RXD:   if (pkt_done || !rx_go) nxt = S_RXE;
      S_RXE:   if (us_tick) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (load)                    cnt <= ld_val;
      else if (us_tick && !expired) cnt <= cnt - 1'b1;
    end
  end

  assign pll_en   = (state >= S_TXS && state <= S_TXD) || (state >= S_RXS && state <= S_RXD);
  assign pa_en    = (state == S_TXPA) || (state == S_TXD);
  assign tx_en    = (state == S_TXD);
  assign rx_en    = (state == S_RXD);
  assign pkt_flag = tx_en || rx_en;
endmodule

// File: rtl/radio_power_seq_props.sv
module radio_power_seq_props (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       sleep_req,
  input logic       tx_go,
  input logic       rx_go,
  input logic       pkt_done,
  input logic       us_tick,
  input logic [3:0] state,
  input logic       pa_en,
  input logic       pkt_flag
);
  assert_init_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd1 |=> state == 4'd2);

  assert_sleep_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd2 && !tx_go && !rx_go && sleep_req && !spi_cs_n) |=> state == 4'd2);

  assert_tx_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd2 && tx_go) |=> state == 4'd4);

  assert_done_waits_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == 4'd8 || state == 4'd12) && !us_tick) |=> $stable(state));

  assert_flag_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_flag) |-> ($past(state) == 4'd6 || $past(state) == 4'd10));

  assert_data_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd7 && pkt_done) |=> state == 4'd8);

  assert_pa_ramp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pa_en) |-> $past(state) == 4'd5);
endmodule

bind radio_power_seq radio_power_seq_props u_props (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .sleep_req(sleep_req),
  .tx_go(tx_go), .rx_go(rx_go), .pkt_done(pkt_done), .us_tick(us_tick),
  .state(state), .pa_en(pa_en), .pkt_flag(pkt_flag)
);

// File: tb/radio_power_seq_test.sv
module radio_power_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_cs_n = 1'b1, sleep_req = 1'b0, tx_go = 1'b0, rx_go = 1'b0;
  logic [7:0] tx_synth_dly = '0, pa_dly = '0, rx_synth_dly = '0;
  logic pkt_done = 1'b0, us_tick = 1'b0;
  logic [3:0] state;
  logic pll_en, pa_en, tx_en, rx_en, pkt_flag;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  radio_power_seq uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .sleep_req(sleep_req),
    .tx_go(tx_go), .rx_go(rx_go), .tx_synth_dly(tx_synth_dly), .pa_dly(pa_dly),
    .rx_synth_dly(rx_synth_dly), .pkt_done(pkt_done), .us_tick(us_tick),
    .state(state), .pll_en(pll_en), .pa_en(pa_en), .tx_en(tx_en), .rx_en(rx_en),
    .pkt_flag(pkt_flag)
  );

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic tick();
    us_tick = 1'b1; step(); us_tick = 1'b0;
  endtask

  function automatic int outs();
    return {pll_en, pa_en, tx_en, rx_en, pkt_flag};
  endfunction

  task automatic wait_phase(input int n, input int st, input int nxt, input string req);
    for (int i = 0; i < n; i++) begin
      check(state, st, req);
      tick();
    end
    check(state, st, req);
    step();
    check(state, nxt, req);
  endtask

  task automatic tx_run(input int a, input int b, input bit by_done);
    tx_synth_dly = 8'(a); pa_dly = 8'(b);
    tx_go = 1'b1; step();
    check(state, 4, "R4 tx start");
    check(outs(), 5'b10000, "R11 start enables");
    step();
    check(outs(), 5'b10000, "R11 synth wait enables");
    wait_phase(a, 5, 6, "R6 tx synth wait");
    check(outs(), 5'b11000, "R11 pa wait enables");
    wait_phase(b, 6, 7, "R6 pa wait");
    check(outs(), 5'b11101, "R9 R11 tx data enables");
    if (by_done) begin pkt_done = 1'b1; step(); pkt_done = 1'b0; tx_go = 1'b0; end
    else begin tx_go = 1'b0; step(); end
    check(state, 8, "R7 tx done");
    check(int'(pkt_flag), 0, "R9 flag falls");
    step();
    check(state, 8, "R8 done holds without tick");
    tick();
    check(state, 2, "R8 back to idle");
  endtask

  task automatic rx_run(input int a, input bit by_done);
    rx_synth_dly = 8'(a);
    rx_go = 1'b1; step();
    check(state, 9, "R5 rx start");
    step();
    wait_phase(a, 10, 11, "R6 rx synth wait");
    check(outs(), 5'b10011, "R9 R11 rx data enables");
    if (by_done) begin pkt_done = 1'b1; step(); pkt_done = 1'b0; rx_go = 1'b0; end
    else begin rx_go = 1'b0; step(); end
    check(state, 12, "R7 rx done");
    check(int'(pkt_flag), 0, "R9 flag falls");
    tick();
    check(state, 2, "R8 back to idle");
  endtask

  initial begin
    int vals[6] = '{0, 1, 2, 3, 7, 255};
    #5;
    check(state, 0, "R1 off in reset");
    check(outs(), 0, "R1 outputs low in reset");
    step(); step();
    check(state, 0, "R1 held off");
    rst_n = 1'b1; step();
    check(state, 1, "R1 init");
    step();
    check(state, 2, "R1 idle");

    spi_cs_n = 1'b0; sleep_req = 1'b1;
    step(); step();
    check(state, 2, "R3 sleep ignored with select low");
    spi_cs_n = 1'b1; step();
    check(state, 3, "R2 sleep entered");
    step();
    check(state, 3, "R2 sleep held");
    sleep_req = 1'b0; step();
    check(state, 2, "R2 wake to idle");

    tx_synth_dly = 8'd0; pa_dly = 8'd0;
    tx_go = 1'b1; rx_go = 1'b1; step();
    check(state, 4, "R10 tx priority");
    rx_go = 1'b0; step(); step(); step();
    check(state, 7, "R10 tx data reached");
    tx_go = 1'b0; step(); tick();
    check(state, 2, "R10 idle again");

    foreach (vals[i]) foreach (vals[j]) tx_run(vals[i], vals[j], ((i + j) % 2) == 0);
    foreach (vals[i]) begin
      rx_run(vals[i], 1'b1);
      rx_run(vals[i], 1'b0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #3000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule